// File: doc/BRIEF.md
# Triple Interval Timer with Shared Prescaler

This block holds three interval timers that draw their time base from one free-running prescale counter. Timers 0 and 1 step once every 128 clocks, and timer 2 steps once every 16 clocks. The prescale counter never stops, and its coarse ticks always fall on a fine tick. Each timer has three parts. A reloadable 8-bit target is the first. An 8-bit interval counter advances on each prescale tick while the timer is enabled. A 4-bit event counter records each match between the interval counter and its target.

Software polls the event counters. Each read is signalled by a per-timer read strobe, and the strobe clears that counter. There are two resets. Power-on reset puts every part in a known state. Soft reset clears the counters but keeps the targets, and it leaves the prescaler's phase unchanged.

Top module: `ptimer_trio`

## Requirements
- R1: The prescaler is cleared only by power-on reset. After power-on reset is released, a slow tick occurs at every 128th clock edge and a fast tick at every 16th. The first slow tick is at edge 128 and the first fast tick is at edge 16. Enables and soft reset have no effect on the prescaler.
- R2: Every slow tick coincides with a fast tick. Timers 0 and 1 use the slow tick and timer 2 uses the fast tick.
- R3: On each tick of an enabled timer, the interval counter is incremented first and then compared. If the new value equals the target, the interval counter becomes 0 and the event counter increments by one in that same edge.
- R4: A target of 0 gives an event every 256 ticks.
- R5: If the target is set below the current interval count, no event occurs until the interval counter wraps past 255 and reaches the new target.
- R6: When a timer's enable goes from 0 to 1, as seen between two consecutive edges, its interval and event counters are cleared.
- R7: A read strobe clears the event counter. If a read strobe and an increment fall on the same edge, the counter becomes 1.
- R8: Power-on reset gives event counters of Fh, targets of 00h and interval counters of 0. Soft reset gives event and interval counters of 0, keeps the targets, and treats each enable as previously low.
- R9: While a timer is disabled, its interval and event counters hold their values, except when a read strobe clears the event counter.
- R10: The event counter wraps from Fh to 0h.
- R11: `evt_cnt[4i+3:4i]` is the event counter of timer i. Asserting `tgt_wr[i]` loads `tgt_data` into timer i's target. A compare on the same edge still uses the old target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| srst | input | 1 | Synchronous soft reset, active high |
| tmr_en | input | 3 | Per-timer enable |
| tgt_wr | input | 3 | Per-timer target write strobe |
| tgt_data | input | 8 | Target value to load |
| rd_clr | input | 3 | Per-timer read strobe, clears the event counter |
| evt_cnt | output | 12 | Three 4-bit event counters, timer 0 in the low nibble |

## Verification
On every cycle, the assertions check four things. Slow and fast ticks must coincide. A counter may change by at most one step between edges, wrap included. A disabled timer must hold its state. Reads, enable rises and soft reset must each leave the value they are meant to leave.

Some behaviour shows only over long stretches, and only the bench's scenarios reach it. These cases are the 256-tick period of a zero target, the long wrap after the target is lowered, the exact phase of the prescaler after reset, and a read that lands on the same edge as an increment. The bench compares every output on every cycle against a cycle model built from the requirements.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  typedef enum logic {
    TICK_SLOW = 1'b0,
    TICK_FAST = 1'b1
  } tick_src_e;

  localparam int unsigned DEF_SLOW_DIV = 128;
  localparam int unsigned DEF_FAST_DIV = 16;
  localparam int unsigned DEF_CNT_W    = 8;
  localparam int unsigned DEF_EVT_W    = 4;
endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
  parameter int unsigned SLOW_DIV = ptimer_pkg::DEF_SLOW_DIV,
  parameter int unsigned FAST_DIV = ptimer_pkg::DEF_FAST_DIV
) (
  input  logic clk,
  input  logic por,
  output logic slow_tick,
  output logic fast_tick
);
  localparam int unsigned PW = $clog2(SLOW_DIV);
  localparam int unsigned FW = $clog2(FAST_DIV);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);

  logic [PW-1:0] pre_q;

  // Only power-on clears the base; it keeps running through everything else.
  always_ff @(posedge clk) begin
    if (por) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // Fast slice is the low bits of the same counter, so coarse ticks sit on fine ones.
  assign slow_tick = (pre_q == SLOW_LAST);
  assign fast_tick = (pre_q[FW-1:0] == FAST_LAST);
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan #(
  parameter int unsigned CNT_W = ptimer_pkg::DEF_CNT_W,
  parameter int unsigned EVT_W = ptimer_pkg::DEF_EVT_W
) (
  input  logic             clk,
  input  logic             por,
  input  logic             srst,
  input  logic             en,
  input  logic             tick,
  input  logic             tgt_we,
  input  logic [CNT_W-1:0] tgt_din,
  input  logic             rd_clr,
  output logic [EVT_W-1:0] evt,
  output logic [CNT_W-1:0] tgt
);
  localparam logic [EVT_W-1:0] EVT_POR = '1;

  logic [CNT_W-1:0] ivl_q;
  logic [EVT_W-1:0] evt_q;
  logic [CNT_W-1:0] tgt_q;
  logic             en_q;
  logic             en_rise;
  logic [CNT_W-1:0] ivl_inc;
  logic             hit;

  assign en_rise = en & ~en_q;
  assign ivl_inc = ivl_q + 1'b1;
  assign hit     = en & tick & (ivl_inc == tgt_q);

  // Target survives soft reset.
  always_ff @(posedge clk) begin
    if (por)         tgt_q <= '0;
    else if (tgt_we) tgt_q <= tgt_din;
  end

  always_ff @(posedge clk) begin
    if (por || srst) en_q <= 1'b0;
    else             en_q <= en;
  end

  always_ff @(posedge clk) begin
    if (por || srst || en_rise) ivl_q <= '0;
    else if (en && tick)        ivl_q <= hit ? '0 : ivl_inc;
  end

  always_ff @(posedge clk) begin
    if (por)                  evt_q <= EVT_POR;
    else if (srst || en_rise) evt_q <= '0;
    else if (rd_clr)          evt_q <= EVT_W'(hit);
    else if (hit)             evt_q <= evt_q + 1'b1;
  end

  assign evt = evt_q;
  assign tgt = tgt_q;
endmodule

// File: rtl/ptimer_trio.sv
module ptimer_trio #(
  parameter int unsigned N_TMR    = 3,
  parameter int unsigned SLOW_DIV = ptimer_pkg::DEF_SLOW_DIV,
  parameter int unsigned FAST_DIV = ptimer_pkg::DEF_FAST_DIV,
  parameter int unsigned CNT_W    = ptimer_pkg::DEF_CNT_W,
  parameter int unsigned EVT_W    = ptimer_pkg::DEF_EVT_W,
  parameter logic [N_TMR-1:0] FAST_SEL = 3'b100
) (
  input  logic                   clk,
  input  logic                   por,
  input  logic                   srst,
  input  logic [N_TMR-1:0]       tmr_en,
  input  logic [N_TMR-1:0]       tgt_wr,
  input  logic [CNT_W-1:0]       tgt_data,
  input  logic [N_TMR-1:0]       rd_clr,
  output logic [N_TMR*EVT_W-1:0] evt_cnt
);
  import ptimer_pkg::*;

  logic                   slow_tick;
  logic                   fast_tick;
  logic [N_TMR*CNT_W-1:0] tgt_all;

  ptimer_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk       (clk),
    .por       (por),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_chan
    localparam tick_src_e SRC = FAST_SEL[i] ? TICK_FAST : TICK_SLOW;
    logic tick_i;
    assign tick_i = (SRC == TICK_FAST) ? fast_tick : slow_tick;

    ptimer_chan #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chan (
      .clk     (clk),
      .por     (por),
      .srst    (srst),
      .en      (tmr_en[i]),
      .tick    (tick_i),
      .tgt_we  (tgt_wr[i]),
      .tgt_din (tgt_data),
      .rd_clr  (rd_clr[i]),
      .evt     (evt_cnt[i*EVT_W +: EVT_W]),
      .tgt     (tgt_all[i*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/ptimer_trio_chk.sv
module ptimer_trio_chk #(
  parameter int unsigned N_TMR = 3,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned EVT_W = 4
) (
  input logic                   clk,
  input logic                   por,
  input logic                   srst,
  input logic [N_TMR-1:0]       tmr_en,
  input logic [N_TMR-1:0]       tgt_wr,
  input logic [N_TMR-1:0]       rd_clr,
  input logic [N_TMR*EVT_W-1:0] evt_cnt,
  input logic [N_TMR*CNT_W-1:0] tgt_all,
  input logic                   slow_tick,
  input logic                   fast_tick
);
  // R2: coarse ticks fall on fine ticks
  p_tick_align_r2: assert property (@(posedge clk) disable iff (por)
    slow_tick |-> fast_tick);

  for (genvar i = 0; i < N_TMR; i++) begin : g_ck
    // R3 and R10: at most one step per edge when nothing clears
    p_step_r3: assert property (@(posedge clk) disable iff (por)
      (!srst && !rd_clr[i] && tmr_en[i] && $past(tmr_en[i]))
      |=> (evt_cnt[i*EVT_W +: EVT_W] == $past(evt_cnt[i*EVT_W +: EVT_W]) ||
           evt_cnt[i*EVT_W +: EVT_W] == $past(evt_cnt[i*EVT_W +: EVT_W]) + 1'b1));

    // R6: enable rise clears the event counter
    p_rise_clear_r6: assert property (@(posedge clk) disable iff (por)
      (tmr_en[i] && !$past(tmr_en[i])) |=> (evt_cnt[i*EVT_W +: EVT_W] == '0));

    // R7: a read leaves 0 or 1
    p_read_clear_r7: assert property (@(posedge clk) disable iff (por)
      rd_clr[i] |=> (evt_cnt[i*EVT_W +: EVT_W] <= 1));

    // R8: soft reset zeroes events and keeps the target
    p_soft_reset_r8: assert property (@(posedge clk) disable iff (por)
      (srst && !tgt_wr[i]) |=> (evt_cnt[i*EVT_W +: EVT_W] == '0 &&
                                $stable(tgt_all[i*CNT_W +: CNT_W])));

    // R9: disabled timer holds
    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (por)
      (!tmr_en[i] && !rd_clr[i] && !srst) |=> $stable(evt_cnt[i*EVT_W +: EVT_W]));
  end
endmodule

bind ptimer_trio ptimer_trio_chk #(.N_TMR(N_TMR), .CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk       (clk),
  .por       (por),
  .srst      (srst),
  .tmr_en    (tmr_en),
  .tgt_wr    (tgt_wr),
  .rd_clr    (rd_clr),
  .evt_cnt   (evt_cnt),
  .tgt_all   (tgt_all),
  .slow_tick (slow_tick),
  .fast_tick (fast_tick)
);

// File: tb/ptimer_trio_tb.sv
module ptimer_trio_tb;
  logic        clk = 1'b0;
  logic        por, srst;
  logic [2:0]  en, wr, rd;
  logic [7:0]  din;
  logic [11:0] evt;

  int vecs = 0;
  int errs = 0;
  int cyc_n = 0;
  bit done = 0;
  string tag = "R8";

  // bench model state
  logic [6:0] m_pre;
  logic [7:0] m_s2 [3];
  logic [3:0] m_s3 [3];
  logic [7:0] m_tgt [3];
  logic       m_enq [3];

  always #2 clk = ~clk;

  ptimer_trio u_dut (
    .clk(clk), .por(por), .srst(srst), .tmr_en(en), .tgt_wr(wr),
    .tgt_data(din), .rd_clr(rd), .evt_cnt(evt)
  );

  function automatic logic [3:0] ev(input int i);
    return evt[i*4 +: 4];
  endfunction

  task automatic model_step();
    logic slow, fast, tk, rise, inc;
    logic [7:0] n;
    if (por) begin
      m_pre = '0;
      for (int i = 0; i < 3; i++) begin
        m_s2[i] = '0; m_s3[i] = 4'hF; m_tgt[i] = '0; m_enq[i] = 1'b0;
      end
    end else begin
      slow = (m_pre == 7'd127);
      fast = (m_pre[3:0] == 4'd15);
      m_pre = m_pre + 1'b1;
      for (int i = 0; i < 3; i++) begin
        tk = (i == 2) ? fast : slow;
        rise = en[i] && !m_enq[i];
        if (srst) begin
          m_s2[i] = '0; m_s3[i] = '0; m_enq[i] = 1'b0;
        end else begin
          m_enq[i] = en[i];
          inc = 1'b0;
          if (rise) begin
            m_s2[i] = '0; m_s3[i] = '0;
          end else begin
            if (en[i] && tk) begin
              n = m_s2[i] + 1'b1;
              if (n == m_tgt[i]) begin m_s2[i] = '0; inc = 1'b1; end
              else m_s2[i] = n;
            end
            if (rd[i]) m_s3[i] = {3'b0, inc};
            else       m_s3[i] = m_s3[i] + {3'b0, inc};
          end
        end
        if (wr[i]) m_tgt[i] = din;
      end
    end
  endtask

  task automatic check(input string t, input logic [3:0] act, input logic [3:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", t, act, exp, cyc_n);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    cyc_n++;
    @(negedge clk);
    for (int i = 0; i < 3; i++) check($sformatf("%s t%0d", tag, i), ev(i), m_s3[i]);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic set_tgt(input int i, input logic [7:0] v);
    wr = 3'b000; wr[i] = 1'b1; din = v; cyc(); wr = 3'b000;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hang expected finish");
    finish_up();
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    por = 1; srst = 0; en = 0; wr = 0; rd = 0; din = 0;
    run(3);
    // R8 power-on values
    check("R8 por t0", ev(0), 4'hF);
    check("R8 por t2", ev(2), 4'hF);
    por = 0;
    tag = "R9";
    run(300);
    check("R9 held", ev(1), 4'hF);
    tag = "R1";
    for (int k = 0; k < 128; k++) begin
      cyc();
    end
    // R1: first slow tick at edge 128; prescaler position known from model phase
    check("R1 phase", {1'b0, m_pre[6:4]}, {1'b0, 3'((300 + 128) % 128 >> 4)});
    tag = "R11";
    set_tgt(0, 8'd3); set_tgt(1, 8'd2); set_tgt(2, 8'd5);
    tag = "R6";
    en = 3'b111; cyc();
    check("R6 clear t0", ev(0), 4'h0);
    check("R6 clear t2", ev(2), 4'h0);
    tag = "R3";
    run(2000);
    check("R3 t2 count", ev(2), m_s3[2]);
    // R7 read on the same edge as an increment
    tag = "R7";
    set_tgt(2, 8'd1);
    while (m_pre[3:0] != 4'd15) cyc();
    rd = 3'b100; cyc(); rd = 3'b000;
    check("R7 coincident", ev(2), 4'h1);
    rd = 3'b001; cyc(); rd = 3'b000;
    check("R7 plain", ev(0), 4'h0);
    // R10 wrap
    tag = "R10";
    run(20 * 16);
    check("R10 wrap", ev(2), m_s3[2]);
    // R2: t0 target 1 and t2 target 8 run together
    tag = "R2";
    set_tgt(0, 8'd1); set_tgt(2, 8'd8);
    en = 3'b000; cyc(); en = 3'b111;
    while (m_pre != 7'd100) cyc();
    run(5 * 128);
    check("R2 equal", ev(0), ev(2));
    // R4 target zero on the fast timer
    tag = "R4";
    set_tgt(2, 8'd0);
    en[2] = 1'b0; cyc(); en[2] = 1'b1;
    run(255 * 16);
    check("R4 early", ev(2), 4'h0);
    run(32);
    check("R4 one", ev(2), 4'h1);
    // R5 lower the target under the count
    tag = "R5";
    set_tgt(2, 8'd100);
    en[2] = 1'b0; cyc(); en[2] = 1'b1;
    while (m_s2[2] < 8'd60) cyc();
    set_tgt(2, 8'd10);
    run(180 * 16);
    check("R5 no event", ev(2), 4'h0);
    run(30 * 16);
    check("R5 after wrap", ev(2), 4'h1);
    // R8 soft reset keeps targets
    tag = "R8";
    srst = 1; cyc(); srst = 0;
    check("R8 soft", ev(1), 4'h0);
    // random mix
    tag = "R1 R11 random";
    for (int k = 0; k < 20000; k++) begin
      if ($urandom_range(0, 199) == 0) en = 3'($urandom);
      else if ($urandom_range(0, 15) == 0) en = 3'b111;
      wr = ($urandom_range(0, 99) == 0) ? 3'($urandom) : 3'b000;
      din = 8'($urandom_range(0, 6));
      rd = ($urandom_range(0, 31) == 0) ? 3'($urandom) : 3'b000;
      srst = ($urandom_range(0, 2999) == 0);
      cnt = k;
      cyc();
    end
    wr = 0; rd = 0; srst = 0;
    tag = "R9";
    en = 3'b000;
    run(400);
    finish_up();
  end
endmodule